// File: doc/BRIEF.md
# Asynchronous Register-Access Bus Slave

This block connects an external processor to an internal 16-bit register file over a demultiplexed, asynchronous parallel bus. The bus carries a 12-bit word address, an active-low chip select, separate active-low read and write strobes, a 16-bit data bus and an active-low ready. The block brings the chip select and both strobes into its own clock domain through two flip-flop stages. It latches the address, and for writes the data, when it first sees a strobe under chip select. After a fixed number of clocks it performs the register-file access and pulls ready low.

The data bus and ready are tri-state at the pad. The block gives each one a value output and an output-enable, and the pad buffers sit at chip level. The data bus is driven only for a read, from the moment ready falls until the read strobe is withdrawn. Once the processor removes its strobe, the block drives ready high again. It keeps ready driven until chip select goes away, so the processor can hold chip select low and start the next access with a new strobe and a new address. The bus has no back-pressure apart from ready: the processor must hold its strobe until ready is low. The register-file side is a fixed-latency port: a one-clock write enable, and read data sampled combinationally.

Top module: `rab_slave`

## Requirements
- R1: While and after reset, and with no bus activity, ready and data output-enables are low, ready value is 1 and the register write enable is 0.
- R2: A read returns, on the data output with its enable high, the register-file word at the 12-bit address presented when the strobe was first seen; the address on the register side stays stable throughout the access.
- R3: A write produces exactly one register write-enable pulse, one clock long, carrying the latched address and data, in the clock at whose end ready falls.
- R4: Ready falls exactly LATENCY+2 rising edges after the first rising edge at which the strobe is seen low with chip select low (two synchronizer stages plus LATENCY clocks).
- R5: The data output-enable is high only during a read, from ready falling until the synchronized read strobe is high again, and never during a write.
- R6: Once the synchronized strobe returns high, ready is driven to 1 and stays driven while chip select remains low.
- R7: After an access completes, ready's output-enable drops once the synchronized chip select is high, and not before.
- R8: With chip select held low, a new strobe starts a new access with a new address, and ready stays driven between the two.
- R9: If both strobes are low together, the access is a read and the register file is not written.
- R10: Strobes with chip select high are ignored: no write enable and ready stays undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 12 | Word address from the processor |
| bus_cs_n_i | input | 1 | Chip select, active low, asynchronous |
| bus_rd_n_i | input | 1 | Read strobe, active low, asynchronous |
| bus_wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| bus_data_i | input | 16 | Data from the pad (write data) |
| bus_data_o | output | 16 | Read data toward the pad |
| bus_data_oe_o | output | 1 | Data pad drive enable |
| bus_rdy_n_o | output | 1 | Ready value, active low |
| bus_rdy_oe_o | output | 1 | Ready pad drive enable |
| reg_addr_o | output | 12 | Register-file address |
| reg_we_o | output | 1 | Register-file write enable, one clock |
| reg_wdata_o | output | 16 | Register-file write data |
| reg_rdata_i | input | 16 | Register-file read data for reg_addr_o |

## Verification
The hardest situation to reach is the back-to-back case with chip select held low. In that case ready must stay driven high through the gap between strobes, and the second address must be taken fresh. The stimulus chains a write, a read and a second write without releasing chip select, and compares ready's enable on every clock against the model. A second hard case is both strobes falling together. The bench drives them in the same cycle, then reads the word back to show that no write slipped through.

// File: rtl/rab_pkg.sv
package rab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HOLD,
    ST_DONE
  } rab_state_e;

  typedef enum logic {
    CMD_READ,
    CMD_WRITE
  } rab_cmd_e;
endpackage

// File: rtl/rab_sync.sv
module rab_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {2{RST_VAL[g]}};
      else        stg <= {stg[0], d_i[g]};
    end
    assign q_o[g] = stg[1];
  end
endmodule

// File: rtl/rab_ctrl.sv
module rab_ctrl
  import rab_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act_i,
  input  logic rd_act_i,
  input  logic wr_act_i,
  output logic start_o,
  output logic complete_o,
  output logic is_read_o,
  output logic we_o,
  output logic rdy_n_o,
  output logic rdy_oe_o,
  output logic dout_oe_o
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LATENCY - 1);

  rab_state_e       state;
  rab_cmd_e         cmd;
  logic [CNT_W-1:0] cnt;
  logic             strobe;

  assign strobe     = rd_act_i | wr_act_i;
  assign start_o    = ((state == ST_IDLE) || (state == ST_DONE)) && cs_act_i && strobe;
  assign complete_o = (state == ST_WAIT) && (cnt == LAST);
  assign is_read_o  = (cmd == CMD_READ);
  assign we_o       = complete_o && (cmd == CMD_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cmd       <= CMD_READ;
      cnt       <= '0;
      rdy_n_o   <= 1'b1;
      rdy_oe_o  <= 1'b0;
      dout_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start_o) begin
            state    <= ST_WAIT;
            cnt      <= '0;
            cmd      <= rd_act_i ? CMD_READ : CMD_WRITE;
            rdy_oe_o <= 1'b1;
          end else if ((state == ST_DONE) && !cs_act_i) begin
            state    <= ST_IDLE;
            rdy_oe_o <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (complete_o) begin
            state     <= ST_HOLD;
            rdy_n_o   <= 1'b0;
            dout_oe_o <= (cmd == CMD_READ);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (!strobe) begin
            state     <= ST_DONE;
            rdy_n_o   <= 1'b1;
            dout_oe_o <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |=> !we_o);
  p_ready_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n_o) |-> ($past(state) == ST_WAIT) && ($past(cnt) == LAST));
  p_dout_with_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe_o |-> (!rdy_n_o && rdy_oe_o && (cmd == CMD_READ)));
  p_ready_low_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n_o |-> rdy_oe_o);
  p_release_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_oe_o) |-> $past(!cs_act_i));
  p_ignore_no_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !cs_act_i) |=> ((state == ST_IDLE) && !rdy_oe_o));
endmodule

// File: rtl/rab_dpath.sv
module rab_dpath #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          complete_i,
  input  logic          is_read_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic [DW-1:0] dout_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      dout_o      <= '0;
    end else begin
      if (start_i) begin
        reg_addr_o  <= addr_i;
        reg_wdata_o <= wdata_i;
      end
      if (complete_i && is_read_i) dout_o <= rdata_i;
    end
  end

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    complete_i |=> $stable(reg_addr_o));
endmodule

// File: rtl/rab_slave.sv
module rab_slave #(
  parameter int AW      = 12,
  parameter int DW      = 16,
  parameter int LATENCY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_cs_n_i,
  input  logic          bus_rd_n_i,
  input  logic          bus_wr_n_i,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe_o,
  output logic          bus_rdy_n_o,
  output logic          bus_rdy_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_we_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);
  logic [2:0] ctl_sync;
  logic       start, complete, is_read;

  rab_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({bus_cs_n_i, bus_rd_n_i, bus_wr_n_i}),
    .q_o   (ctl_sync)
  );

  rab_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act_i   (!ctl_sync[2]),
    .rd_act_i   (!ctl_sync[1]),
    .wr_act_i   (!ctl_sync[0]),
    .start_o    (start),
    .complete_o (complete),
    .is_read_o  (is_read),
    .we_o       (reg_we_o),
    .rdy_n_o    (bus_rdy_n_o),
    .rdy_oe_o   (bus_rdy_oe_o),
    .dout_oe_o  (bus_data_oe_o)
  );

  rab_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .complete_i  (complete),
    .is_read_i   (is_read),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_data_i),
    .rdata_i     (reg_rdata_i),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .dout_o      (bus_data_o)
  );
endmodule

// File: tb/test_rab_slave.sv
module test_rab_slave;
  localparam int AW  = 12;
  localparam int DW  = 16;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [DW-1:0] bus_din = '0;
  logic [DW-1:0] bus_dout;
  logic          bus_doe, bus_rdy_n, bus_rdy_oe;
  logic [AW-1:0] reg_addr;
  logic          reg_we;
  logic [DW-1:0] reg_wdata, reg_rdata;

  int checks = 0, fails = 0, cycles = 0, we_count = 0;

  always #2 clk = ~clk;

  rab_slave #(.AW(AW), .DW(DW), .LATENCY(LAT)) i_rab_slave (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_cs_n_i(bus_cs_n),
    .bus_rd_n_i(bus_rd_n), .bus_wr_n_i(bus_wr_n), .bus_data_i(bus_din),
    .bus_data_o(bus_dout), .bus_data_oe_o(bus_doe), .bus_rdy_n_o(bus_rdy_n),
    .bus_rdy_oe_o(bus_rdy_oe), .reg_addr_o(reg_addr), .reg_we_o(reg_we),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  function automatic logic [DW-1:0] init_val(int i);
    return DW'(i * 37) ^ 16'hA5C3;
  endfunction

  logic [DW-1:0] regfile [4096];
  logic [DW-1:0] shadow  [4096];
  initial for (int i = 0; i < 4096; i++) begin
    regfile[i] = init_val(i);
    shadow[i]  = init_val(i);
  end
  always @(posedge clk) if (reg_we) regfile[reg_addr] <= reg_wdata;
  assign reg_rdata = regfile[reg_addr];
  always @(posedge clk) if (rst_n && reg_we) we_count++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  logic [2:0]    m_s1 = 3'b111, m_s2 = 3'b111;
  int            ph = 0, cnt = 0;
  bit            cur_read = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_wdata = '0, exp_dout = '0;
  bit            exp_rdy_n = 1, exp_rdy_oe = 0, exp_doe = 0;

  always @(posedge clk) begin
    bit cs, rd, wr;
    if (!rst_n) begin
      m_s1 = 3'b111; m_s2 = 3'b111; ph = 0; cnt = 0;
      exp_rdy_n = 1; exp_rdy_oe = 0; exp_doe = 0;
    end else begin
      cs = !m_s2[2]; rd = !m_s2[1]; wr = !m_s2[0];
      case (ph)
        0, 3: begin
          if (cs && (rd || wr)) begin
            ph = 1; cnt = 0; cur_read = rd; cur_addr = bus_addr;
            cur_wdata = bus_din; exp_rdy_oe = 1;
          end else if (ph == 3 && !cs) begin
            ph = 0; exp_rdy_oe = 0;
          end
        end
        1: begin
          if (cnt == LAT - 1) begin
            ph = 2; exp_rdy_n = 0;
            if (cur_read) begin exp_doe = 1; exp_dout = shadow[cur_addr]; end
            else shadow[cur_addr] = cur_wdata;
          end else cnt++;
        end
        2: if (!(rd || wr)) begin exp_rdy_n = 1; exp_doe = 0; ph = 3; end
        default: ph = 0;
      endcase
      m_s2 = m_s1;
      m_s1 = {bus_cs_n, bus_rd_n, bus_wr_n};
    end
  end

  always @(negedge clk) begin
    bit exp_we;
    exp_we = (ph == 1) && (cnt == LAT - 1) && !cur_read;
    check(bus_rdy_oe == exp_rdy_oe, "R7 ready enable", 32'(bus_rdy_oe), 32'(exp_rdy_oe));
    if (exp_rdy_oe)
      check(bus_rdy_n == exp_rdy_n, "R6 ready value", 32'(bus_rdy_n), 32'(exp_rdy_n));
    check(bus_doe == exp_doe, "R5 data enable", 32'(bus_doe), 32'(exp_doe));
    if (exp_doe) check(bus_dout == exp_dout, "R2 read data", 32'(bus_dout), 32'(exp_dout));
    check(reg_we == exp_we, "R3 write enable", 32'(reg_we), 32'(exp_we));
    if (exp_we) begin
      check(reg_addr == cur_addr, "R3 write address", 32'(reg_addr), 32'(cur_addr));
      check(reg_wdata == cur_wdata, "R3 write data", 32'(reg_wdata), 32'(cur_wdata));
    end
    if (ph != 0) check(reg_addr == cur_addr, "R2 address held", 32'(reg_addr), 32'(cur_addr));
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic access(input bit is_rd, input bit both, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit keep_cs,
                        output logic [DW-1:0] rdata, output bit doe, output int lat);
    @(negedge clk);
    bus_addr = a; bus_din = d; bus_cs_n = 1'b0;
    @(negedge clk);
    if (both) begin bus_rd_n = 1'b0; bus_wr_n = 1'b0; end
    else if (is_rd) bus_rd_n = 1'b0;
    else bus_wr_n = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!(bus_rdy_oe && !bus_rdy_n) && lat < 50);
    rdata = bus_dout; doe = bus_doe;
    bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    check(bus_rdy_oe && bus_rdy_n, "R6 ready high and driven after strobe",
          32'({bus_rdy_oe, bus_rdy_n}), 32'h3);
    check(!bus_doe, "R5 data released", 32'(bus_doe), 32'h0);
    if (!keep_cs) begin
      bus_cs_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!bus_rdy_oe, "R7 ready released after chip select", 32'(bus_rdy_oe), 32'h0);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit keep);
    logic [DW-1:0] r; bit oe; int lat, w0;
    w0 = we_count;
    access(1'b0, 1'b0, a, d, keep, r, oe, lat);
    check(lat == LAT + 3, "R4 write latency", 32'(lat), 32'(LAT + 3));
    check(!oe, "R5 no drive on write", 32'(oe), 32'h0);
    check(we_count - w0 == 1, "R3 one write pulse", 32'(we_count - w0), 32'h1);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input bit keep);
    logic [DW-1:0] r; bit oe; int lat, w0;
    w0 = we_count;
    access(1'b1, 1'b0, a, 16'h0, keep, r, oe, lat);
    check(lat == LAT + 3, "R4 read latency", 32'(lat), 32'(LAT + 3));
    check(oe, "R2 data driven at ready", 32'(oe), 32'h1);
    check(r == exp, "R2 read value", 32'(r), 32'(exp));
    check(we_count == w0, "R2 read causes no write", 32'(we_count - w0), 32'h0);
  endtask

  initial begin
    logic [DW-1:0] r; bit oe; int lat, w0;
    repeat (3) @(negedge clk);
    check(!bus_rdy_oe && bus_rdy_n && !bus_doe && !reg_we, "R1 reset outputs",
          32'({bus_rdy_oe, bus_rdy_n, bus_doe, reg_we}), 32'b0100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!bus_rdy_oe && bus_rdy_n && !bus_doe && !reg_we, "R1 idle after reset",
          32'({bus_rdy_oe, bus_rdy_n, bus_doe, reg_we}), 32'b0100);

    do_write(12'h000, 16'h1234, 0);
    do_read (12'h000, 16'h1234, 0);
    do_write(12'hFFF, 16'hFFFF, 0);
    do_read (12'hFFF, 16'hFFFF, 0);
    do_write(12'h800, 16'h0000, 0);
    do_read (12'h800, 16'h0000, 0);
    do_read (12'h3C5, init_val(12'h3C5), 0);

    // R8: chained accesses with chip select held low
    do_write(12'h010, 16'hBEEF, 1);
    check(bus_rdy_oe && bus_rdy_n, "R8 ready kept driven between accesses",
          32'({bus_rdy_oe, bus_rdy_n}), 32'h3);
    do_read(12'h010, 16'hBEEF, 1);
    do_write(12'h011, 16'h0F0F, 0);
    do_read(12'h011, 16'h0F0F, 0);
    do_read(12'h010, 16'hBEEF, 0);

    // R9: both strobes together act as a read
    w0 = we_count;
    access(1'b0, 1'b1, 12'h020, 16'hDEAD, 0, r, oe, lat);
    check(oe && r == init_val(12'h020), "R9 both strobes read", 32'(r), 32'(init_val(12'h020)));
    check(we_count == w0, "R9 no write on both strobes", 32'(we_count - w0), 32'h0);
    do_read(12'h020, init_val(12'h020), 0);

    // R10: strobe with chip select high is ignored
    w0 = we_count;
    @(negedge clk);
    bus_addr = 12'h055; bus_din = 16'h7777; bus_wr_n = 1'b0;
    repeat (10) @(negedge clk);
    check(!bus_rdy_oe, "R10 ready undriven without chip select", 32'(bus_rdy_oe), 32'h0);
    check(we_count == w0, "R10 no write without chip select", 32'(we_count - w0), 32'h0);
    bus_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(12'h055, init_val(12'h055), 0);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule